// File: doc/BRIEF.md
# Video DRAM Random-Access Port with Masked Block Write

This block is a clock-sampled, cycle-level model of the random-access port of a dual-port video memory. The port is driven by two active-low strobes, a row strobe and a column strobe. The block samples both strobes on every clock and finds their falling edges. When the row strobe falls, it captures the row address, an I/O bit mask and the cycle qualifiers. Each later fall of the column strobe within the open row completes a column access.

Three kinds of column access are supported:
- a normal read, whose word appears on a registered output;
- a normal write, optionally restricted bit by bit by the mask captured with the row;
- a block write, which copies an internal color register into an aligned group of four columns. Each column in the group can be switched off by a column mask, and each bit by the I/O mask.

Several column accesses may share one open row (fast page operation). The color register is loaded through a plain synchronous load port.

The array holds 2^ADDR_W rows of 2^ADDR_W words, each DATA_W bits wide. The full-size part uses ADDR_W = 8 and DATA_W = 8, giving 256 rows of 256 eight-bit words. The default build uses ADDR_W = 4 to keep elaboration small.

Top module: `vdram_port`

## Requirements
- R1: While reset is held and after it is released, with both strobes high, `dout_vld` is 0.
- R2: A column-strobe fall with `wr_n` high in a non-block cycle is a read. The addressed word drives `dout`, and `dout_vld` rises one clock after the clock edge at which the fall is detected. Both then hold until `out_en_n` or `row_stb_n` is sampled high.
- R3: The row address is taken from `addr` when the row strobe falls, and the column address is taken from `addr` when the column strobe falls. Several column cycles under one row-strobe low period all address that row. The array is written only at a column-strobe fall.
- R4: If `wr_n` is low when the row strobe falls, the value on `din` at that edge becomes the I/O mask. A written bit with mask 1 takes new data, and a bit with mask 0 keeps its old value. If `wr_n` is high at that edge, all bits are written.
- R5: The mask captured at the row-strobe fall applies unchanged to every write in that open row, whatever `din` carries at later row or column edges.
- R6: A block write occurs only under two conditions. At the row-strobe fall, `col_stb_n` and `out_en_n` must be high and `func_sel` low. At the column-strobe fall, `func_sel` must be high. If either condition is not met, the column cycle is a normal read or write, selected by `wr_n`.
- R7: A block write covers columns {addr[ADDR_W-1:2], k} for k = 0 to 3. The column-address bits 1:0 have no effect. Each enabled column receives the color register value.
- R8: In a block write, `din[k]` at the column-strobe fall enables column offset k, where 1 means write and 0 means keep. `din[DATA_W-1:4]` has no effect.
- R9: In a block write with the I/O mask enabled, each enabled column gets (old & ~mask) | (color & mask).
- R10: A row-strobe low period with no column-strobe fall leaves the array unchanged. A column-strobe fall while the row strobe is high is ignored.
- R11: The color register takes `color_in` on a clock edge where `color_ld` is 1. A block write at that same edge uses the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| row_stb_n | input | 1 | Active-low row strobe |
| col_stb_n | input | 1 | Active-low column strobe |
| wr_n | input | 1 | Write select at the column edge; mask enable (low) at the row edge |
| out_en_n | input | 1 | Active-low output enable, also a block-write qualifier at the row edge |
| func_sel | input | 1 | Special-function select (low at the row edge, high at the column edge for a block write) |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | DATA_W | Write data, I/O mask (row edge) or column mask (block column edge) |
| color_ld | input | 1 | Color register load strobe |
| color_in | input | DATA_W | Color register load value |
| dout | output | DATA_W | Registered read data |
| dout_vld | output | 1 | Read data valid |

## Verification
The assertions check the following on every cycle:
- read-valid timing: `dout_vld` rises exactly two clocks after a column-strobe fall with `wr_n` high;
- the output release rule;
- stability of `dout` while it is held;
- array writes happen only under an open row at a column-strobe fall;
- more than one column is written only in a block write.

Data content can only be shown by the bench's scenarios, compared against a behavioural model on every clock. This covers merging under the I/O mask, persistence of the mask across a page, alignment and column masking of block writes, the fallback to normal cycles, and a refresh-only row cycle leaving the array untouched.

// File: rtl/vdram_pkg.sv
package vdram_pkg;
  // Block write always spans an aligned group of this many columns
  localparam int BLK_SHIFT = 2;
  localparam int BLK_LANES = 1 << BLK_SHIFT;

  typedef enum logic [1:0] {
    CYC_NONE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2,
    CYC_BLOCK = 2'd3
  } cyc_e;
endpackage

// File: rtl/vdram_cyc_dec.sv
// Two-stage cycle decode: row-strobe edge latches row context,
// column-strobe edge resolves the access type.
module vdram_cyc_dec
  import vdram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_i,
  input  logic                 row_stb_n,
  input  logic                 col_stb_n,
  input  logic                 wr_n,
  input  logic                 out_en_n,
  input  logic                 func_sel,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    din,
  output cyc_e                 cyc,
  output logic [ADDR_W-1:0]    row,
  output logic [ADDR_W-1:0]    col,
  output logic [BLK_LANES-1:0] colmask,
  output logic [DATA_W-1:0]    bitmask
);
  logic              ras_q, cas_q, open_q, arm_q, men_q;
  logic              open_d, arm_d, men_d;
  logic [ADDR_W-1:0] row_q, row_d;
  logic [DATA_W-1:0] iom_q, iom_d;
  logic              ras_fall, cas_fall;

  assign ras_fall = ras_q & ~row_stb_n;
  assign cas_fall = cas_q & ~col_stb_n & open_q & ~row_stb_n;

  always_comb begin
    open_d = open_q;
    arm_d  = arm_q;
    men_d  = men_q;
    row_d  = row_q;
    iom_d  = iom_q;
    if (row_stb_n) begin
      open_d = 1'b0;
    end else if (ras_fall) begin
      open_d = 1'b1;
      row_d  = addr;
      iom_d  = din;
      men_d  = ~wr_n;
      arm_d  = col_stb_n & out_en_n & ~func_sel;
    end
  end

  always_comb begin
    if (!cas_fall)             cyc = CYC_NONE;
    else if (arm_q && func_sel) cyc = CYC_BLOCK;
    else if (!wr_n)            cyc = CYC_WRITE;
    else                       cyc = CYC_READ;
  end

  assign row     = row_q;
  assign col     = addr;
  assign colmask = din[BLK_LANES-1:0];
  assign bitmask = men_q ? iom_q : {DATA_W{1'b1}};

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ras_q  <= 1'b1;
      cas_q  <= 1'b1;
      open_q <= 1'b0;
      arm_q  <= 1'b0;
      men_q  <= 1'b0;
      row_q  <= '0;
      iom_q  <= '0;
    end else begin
      ras_q  <= row_stb_n;
      cas_q  <= col_stb_n;
      open_q <= open_d;
      arm_q  <= arm_d;
      men_q  <= men_d;
      row_q  <= row_d;
      iom_q  <= iom_d;
    end
  end
endmodule

// File: rtl/vdram_array.sv
// Storage with a four-lane masked write port and one registered read port.
module vdram_array
  import vdram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic [ADDR_W-1:0]         wr_row,
  input  logic [ADDR_W-BLK_SHIFT-1:0] wr_base,
  input  logic [BLK_LANES-1:0]      lane_en,
  input  logic [DATA_W-1:0]         src,
  input  logic [DATA_W-1:0]         bitmask,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         rd_row,
  input  logic [ADDR_W-1:0]         rd_col,
  output logic [DATA_W-1:0]         rd_q
);
  localparam int IDX_W = 2 * ADDR_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  lane_idx [BLK_LANES];
  logic [DATA_W-1:0] merged   [BLK_LANES];

  for (genvar k = 0; k < BLK_LANES; k++) begin : g_lane
    assign lane_idx[k] = {wr_row, wr_base, BLK_SHIFT'(k)};
    assign merged[k]   = (mem[lane_idx[k]] & ~bitmask) | (src & bitmask);
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < BLK_LANES; k++) begin
      if (lane_en[k]) mem[lane_idx[k]] <= merged[k];
    end
    if (rd_en) rd_q <= mem[{rd_row, rd_col}];
  end
endmodule

// File: rtl/vdram_port.sv
module vdram_port
  import vdram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_stb_n,
  input  logic              col_stb_n,
  input  logic              wr_n,
  input  logic              out_en_n,
  input  logic              func_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              color_ld,
  input  logic [DATA_W-1:0] color_in,
  output logic [DATA_W-1:0] dout,
  output logic              dout_vld
);
  logic [1:0]           rst_sq;
  logic                 rst_i;
  cyc_e                 cyc;
  logic [ADDR_W-1:0]    row, col;
  logic [BLK_LANES-1:0] colmask, lane_en;
  logic [DATA_W-1:0]    bitmask, src;
  logic [DATA_W-1:0]    color_q, color_d;
  logic                 rd_go_q, rd_go_d, vld_q, vld_d;
  logic [ADDR_W-1:0]    rd_row_q, rd_row_d, rd_col_q, rd_col_d;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_i = rst_sq[1];

  vdram_cyc_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst_i(rst_i), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
    .wr_n(wr_n), .out_en_n(out_en_n), .func_sel(func_sel), .addr(addr),
    .din(din), .cyc(cyc), .row(row), .col(col), .colmask(colmask),
    .bitmask(bitmask)
  );

  always_comb begin
    case (cyc)
      CYC_BLOCK: lane_en = colmask;
      CYC_WRITE: lane_en = BLK_LANES'(1) << col[BLK_SHIFT-1:0];
      default:   lane_en = '0;
    endcase
    src = (cyc == CYC_BLOCK) ? color_q : din;
  end

  always_comb begin
    color_d  = color_ld ? color_in : color_q;
    rd_go_d  = (cyc == CYC_READ);
    rd_row_d = rd_go_d ? row : rd_row_q;
    rd_col_d = rd_go_d ? col : rd_col_q;
    if (rd_go_q)                    vld_d = 1'b1;
    else if (out_en_n || row_stb_n) vld_d = 1'b0;
    else                            vld_d = vld_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      color_q  <= '0;
      rd_go_q  <= 1'b0;
      vld_q    <= 1'b0;
      rd_row_q <= '0;
      rd_col_q <= '0;
    end else begin
      color_q  <= color_d;
      rd_go_q  <= rd_go_d;
      vld_q    <= vld_d;
      rd_row_q <= rd_row_d;
      rd_col_q <= rd_col_d;
    end
  end

  vdram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .wr_row(row), .wr_base(col[ADDR_W-1:BLK_SHIFT]),
    .lane_en(lane_en), .src(src), .bitmask(bitmask), .rd_en(rd_go_q),
    .rd_row(rd_row_q), .rd_col(rd_col_q), .rd_q(dout)
  );

  assign dout_vld = vld_q;
endmodule

// File: rtl/vdram_port_chk.sv
module vdram_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_i,
  input logic              row_stb_n,
  input logic              col_stb_n,
  input logic              wr_n,
  input logic              out_en_n,
  input logic              func_sel,
  input logic [3:0]        lane_en,
  input logic [DATA_W-1:0] dout,
  input logic              dout_vld
);
  // R2
  vld_rise_timing_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(dout_vld) |-> ($past(col_stb_n, 3) && !$past(col_stb_n, 2) && $past(wr_n, 2)));

  // R2
  vld_release_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(dout_vld) |-> ($past(row_stb_n) || $past(out_en_n)));

  // R2
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (dout_vld && $past(dout_vld) && $past(col_stb_n, 2)) |-> $stable(dout));

  // R10
  write_needs_row_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (|lane_en) |-> (!row_stb_n && !col_stb_n));

  // R3
  write_on_col_edge_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (|lane_en) |-> $past(col_stb_n));

  // R7
  multi_col_only_block_chk: assert property (@(posedge clk) disable iff (!rst_i)
    ($countones(lane_en) > 1) |-> func_sel);
endmodule

bind vdram_port vdram_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_i(rst_i), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
  .wr_n(wr_n), .out_en_n(out_en_n), .func_sel(func_sel), .lane_en(lane_en),
  .dout(dout), .dout_vld(dout_vld)
);

// File: tb/test_vdram_port.sv
module test_vdram_port;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NCOL = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          row_stb_n = 1'b1, col_stb_n = 1'b1, wr_n = 1'b1;
  logic          out_en_n = 1'b1, func_sel = 1'b0, color_ld = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0, color_in = '0;
  logic [DW-1:0] dout;
  logic          dout_vld;

  int    checks = 0, fails = 0, wd = 0;
  string cur_req = "R1";
  bit    run_cmp = 1'b0;

  always #2.5 clk = ~clk;

  vdram_port i_vdram_port (
    .clk(clk), .rst_n(rst_n), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
    .wr_n(wr_n), .out_en_n(out_en_n), .func_sel(func_sel), .addr(addr),
    .din(din), .color_ld(color_ld), .color_in(color_in), .dout(dout),
    .dout_vld(dout_vld)
  );

  // ---------------- behavioural reference model ----------------
  logic [DW-1:0] mmem [NCOL*NCOL];
  bit   m_ras = 1, m_cas = 1, m_open = 0, m_arm = 0, m_men = 0, m_go = 0, m_vld = 0;
  int   m_row = 0, m_rdi = 0;
  logic [DW-1:0] m_mask = '0, m_color = '0, m_dout = '0;

  function automatic logic [DW-1:0] mrg(logic [DW-1:0] o, logic [DW-1:0] n, logic [DW-1:0] m);
    return (o & ~m) | (n & m);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ras = 1; m_cas = 1; m_open = 0; m_arm = 0; m_men = 0;
      m_go = 0; m_vld = 0; m_color = '0;
    end else begin
      bit            go_n;
      logic [DW-1:0] em;
      go_n = 0;
      if (m_go) begin m_dout = mmem[m_rdi]; m_vld = 1; end
      else if (out_en_n || row_stb_n) m_vld = 0;
      em = m_men ? m_mask : '1;
      if (m_cas && !col_stb_n && m_open && !row_stb_n) begin
        if (m_arm && func_sel) begin
          for (int k = 0; k < 4; k++)
            if (din[k]) begin
              int ix;
              ix = m_row * NCOL + ((int'(addr) / 4) * 4 + k);
              mmem[ix] = mrg(mmem[ix], m_color, em);
            end
        end else if (!wr_n) begin
          mmem[m_row*NCOL+int'(addr)] = mrg(mmem[m_row*NCOL+int'(addr)], din, em);
        end else begin
          go_n = 1; m_rdi = m_row * NCOL + int'(addr);
        end
      end
      m_go = go_n;
      if (row_stb_n) m_open = 0;
      else if (m_ras) begin
        m_open = 1; m_row = int'(addr); m_mask = din; m_men = !wr_n;
        m_arm = col_stb_n && out_en_n && !func_sel;
      end
      if (color_ld) m_color = color_in;
      m_ras = row_stb_n; m_cas = col_stb_n;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(bit ok, string req, logic [DW:0] act, logic [DW:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (run_cmp) begin
      chk(dout_vld === m_vld, {cur_req, " valid"}, {1'b0, 7'd0, dout_vld}, {1'b0, 7'd0, m_vld});
      if (m_vld) chk(dout === m_dout, {cur_req, " data"}, {1'b0, dout}, {1'b0, m_dout});
    end
  end

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      fails++;
      $display("FAIL watchdog (all requirements): run did not finish");
      report();
      $finish;
    end
  end

  // ---------------- stimulus tasks (start and end at a negedge) ----------------
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_color(logic [DW-1:0] c);
    color_ld = 1; color_in = c; @(negedge clk); color_ld = 0;
  endtask

  task automatic ras_on(int row, bit we, bit oe, bit fs, logic [DW-1:0] d);
    row_stb_n = 0; col_stb_n = 1; addr = AW'(row); wr_n = we; out_en_n = oe;
    func_sel = fs; din = d;
    @(negedge clk);
  endtask

  task automatic cas_on(int col, bit we, bit oe, bit fs, logic [DW-1:0] d);
    col_stb_n = 0; addr = AW'(col); wr_n = we; out_en_n = oe; func_sel = fs; din = d;
    repeat (2) @(negedge clk);
    col_stb_n = 1;
    @(negedge clk);
  endtask

  task automatic ras_off;
    row_stb_n = 1; col_stb_n = 1; func_sel = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic read_row(int row, int first, int last);
    ras_on(row, 1, 0, 0, 8'h00);
    for (int c = first; c <= last; c++) cas_on(c, 1, 0, 0, 8'h00);
    ras_off();
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(dout_vld === 1'b0, "R1 in reset", {1'b0, 7'd0, dout_vld}, 9'd0);
    rst_n = 1;
    idle(4);
    chk(dout_vld === 1'b0, "R1 after reset", {1'b0, 7'd0, dout_vld}, 9'd0);
    run_cmp = 1;

    // R6 R7 R11: fill rows 0..3 with unmasked block writes, new color per group
    cur_req = "R7";
    for (int r = 0; r < 4; r++) begin
      ras_on(r, 1, 1, 0, 8'h00);
      for (int g = 0; g < NCOL / 4; g++) begin
        load_color(DW'(8'h11 * (r + 1) + g * 8'h20 + 8'h03));
        cas_on(g * 4 + (g % 4), 1, 1, 1, 8'h0F);
      end
      ras_off();
    end
    cur_req = "R3";
    for (int r = 0; r < 4; r++) read_row(r, 0, NCOL - 1);

    // R3: plain unmasked write in row 2, then page read
    cur_req = "R3";
    ras_on(2, 1, 1, 0, 8'hFF);
    cas_on(5, 0, 1, 0, 8'h3C);
    ras_off();
    read_row(2, 4, 6);

    // R4 R5: write-per-bit mask F0 held over a page of writes
    cur_req = "R5";
    ras_on(2, 0, 1, 0, 8'hF0);
    cas_on(1, 0, 1, 0, 8'hFF);
    cas_on(2, 0, 1, 0, 8'h00);
    cas_on(7, 0, 1, 0, 8'h5A);
    ras_off();
    cur_req = "R4";
    read_row(2, 0, 8);

    // R8 R9 R11: masked block write, addr bits 1:0 set, upper din bits set
    cur_req = "R9";
    load_color(8'h3C);
    ras_on(3, 0, 1, 0, 8'h0F);
    load_color(8'hC3);   // loaded while the row is open, before the column edge
    cas_on(6, 1, 1, 1, 8'hF5);
    ras_off();
    cur_req = "R8";
    read_row(3, 0, 11);

    // R11: load and block write at the same edge uses the old color
    cur_req = "R11";
    ras_on(1, 1, 1, 0, 8'h00);
    color_ld = 1; color_in = 8'h99;
    col_stb_n = 0; addr = 4'd8; func_sel = 1; din = 8'h02;
    @(negedge clk); color_ld = 0;
    @(negedge clk); col_stb_n = 1; @(negedge clk);
    ras_off();
    read_row(1, 8, 11);

    // R6: armed row but func_sel low at column edge -> normal write
    cur_req = "R6";
    load_color(8'hEE);
    ras_on(0, 1, 1, 0, 8'h00);
    cas_on(9, 0, 1, 0, 8'h77);
    ras_off();
    // R6: not armed (out_en_n low at row edge) with func_sel high -> normal read
    ras_on(0, 1, 0, 0, 8'h00);
    cas_on(9, 1, 0, 1, 8'h0F);
    cas_on(8, 1, 0, 1, 8'h0F);
    ras_off();
    // R6: func_sel high at row edge, then high at column edge with write -> normal write
    ras_on(0, 1, 1, 1, 8'h00);
    cas_on(12, 0, 1, 1, 8'h0F);
    ras_off();
    read_row(0, 8, 15);

    // R10: refresh-only row cycle and stray column strobe with row closed
    cur_req = "R10";
    ras_on(1, 0, 1, 0, 8'hFF);
    idle(3);
    ras_off();
    col_stb_n = 0; addr = 4'd3; wr_n = 0; din = 8'hAA; idle(2);
    col_stb_n = 1; wr_n = 1; idle(2);
    read_row(1, 0, NCOL - 1);

    // R2: output holds in the page, then releases on out_en_n high
    cur_req = "R2";
    ras_on(2, 1, 0, 0, 8'h00);
    cas_on(7, 1, 0, 0, 8'h00);
    idle(4);
    chk(dout_vld === 1'b1, "R2 hold", {1'b0, 7'd0, dout_vld}, 9'd1);
    out_en_n = 1; idle(1);
    chk(dout_vld === 1'b0, "R2 release by out_en_n", {1'b0, 7'd0, dout_vld}, 9'd0);
    out_en_n = 0;
    cas_on(1, 1, 0, 0, 8'h00);
    row_stb_n = 1; idle(1);
    chk(dout_vld === 1'b0, "R2 release by row strobe", {1'b0, 7'd0, dout_vld}, 9'd0);
    idle(3);

    run_cmp = 0;
    report();
    $finish;
  end
endmodule